// File: doc/BRIEF.md
# Debug Link Command Unit

This unit runs on the link clock at the host end of a debug connection. The host sends it a stream of bytes, each qualified by a valid strobe. Each byte is either a one-byte command or a data byte that belongs to the command before it. The unit answers with response bytes on a separate valid-qualified output. It can echo bytes back to test the link. It can raise a reset request to the target system for a set minimum time. It can report the sampled level of the target clock or of the active-low target reset. It can also report whether the target clock has toggled since a clear command.

Commands are single opcode bytes: 0x01 echo, 0x02 reset request, 0x03 sample clock, 0x04 sample reset, 0x05 clear activity flag, 0x06 read activity flag. Target inputs enter the link domain through two-flop synchronizers. The activity flag is set in the target clock domain and is then synchronized in the same way. The length of the reset request is a parameter counted in link-clock cycles, and its default equals one second at 50 MHz.

Top module: `dbg_cmd_unit`

## Requirements
- R1: After opcode 0x01, the next accepted byte is returned unchanged on `rsp_byte` with `rsp_valid` high, in the cycle that follows its acceptance. The opcode byte itself produces no response.
- R2: Opcode 0x02 drives `rst_req` high from the cycle after acceptance for exactly `RST_CYCLES` link-clock cycles. No response byte is produced.
- R3: A 0x02 accepted while `rst_req` is high reloads the full `RST_CYCLES` count, so the pulse is lengthened and never shortened.
- R4: Opcode 0x03 returns one response whose bit 0 is the synchronized `tgt_clk` level and whose bits 7:1 are zero.
- R5: Opcode 0x04 returns one response whose bit 0 is the synchronized `tgt_rst_n` level and whose bits 7:1 are zero.
- R6: A rising edge on `tgt_clk` sets an activity flag. Opcode 0x06 returns the flag in bit 0, with zeros above, and does not clear it.
- R7: Opcode 0x05 clears the activity flag and produces no response.
- R8: Opcodes 0x00 and 0x07 to 0xFF produce no response, do not affect `rst_req`, and leave the decoder ready for the next opcode.
- R9: Responses leave in the order their commands arrived. A byte that follows 0x01 is always treated as data, even when its value matches an opcode.
- R10: During and after reset, `rsp_valid` and `rst_req` are low and the activity flag is clear.
- R11: Echo and sample commands are answered while `rst_req` is high, and they leave the end of the pulse unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Link-domain asynchronous reset, active low |
| cmd_valid | input | 1 | Qualifies `cmd_byte` |
| cmd_byte | input | 8 | Opcode or data byte from the host |
| rsp_valid | output | 1 | Qualifies `rsp_byte` |
| rsp_byte | output | 8 | Response byte to the host |
| tgt_clk | input | 1 | Target clock being observed |
| tgt_rst_n | input | 1 | Target reset being observed, active low |
| rst_req | output | 1 | Reset request to the target system |

## Verification
The reset request timer and the response path work independently, so a pulse can be counting down in the same cycle that an echo or a sample answer leaves the unit. The bench starts a pulse and runs several echo exchanges plus a clock sample inside it. Each answer is compared with its expected value, and `rst_req` is checked to stay high until exactly `RST_CYCLES` cycles after the reset command was accepted and to be low one cycle later. The second collision is a reset command arriving while a pulse is already active. It is judged by counting the total high time, which must equal the cycles already elapsed plus a full reload.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
    localparam logic [7:0] OP_ECHO     = 8'h01;
    localparam logic [7:0] OP_RESET    = 8'h02;
    localparam logic [7:0] OP_SMP_CLK  = 8'h03;
    localparam logic [7:0] OP_SMP_RST  = 8'h04;
    localparam logic [7:0] OP_ACT_CLR  = 8'h05;
    localparam logic [7:0] OP_ACT_READ = 8'h06;

    // Synchronized target signal positions
    localparam int SYN_CLK = 0;
    localparam int SYN_RST = 1;
    localparam int SYN_ACT = 2;
    localparam int SYN_W   = 3;

    typedef enum logic {
        DEC_OPCODE = 1'b0,
        DEC_DATA   = 1'b1
    } dec_state_e;

    typedef struct packed {
        dec_state_e  state;
        logic        rsp_v;
        logic [7:0]  rsp_b;
        logic        act_clr;
    } dec_regs_t;
endpackage

// File: rtl/dbg_sync2.sv
module dbg_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_regs_t;

    sync_regs_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = async_in;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.stable;
endmodule

// File: rtl/dbg_rst_timer.sv
module dbg_rst_timer #(
    parameter int RST_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic rst_req
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)            cnt_d = LOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rst_req = (cnt_q != '0);
endmodule

// File: rtl/dbg_act_flag.sv
module dbg_act_flag (
    input  logic tgt_clk,
    input  logic clr,
    output logic active
);
    logic act_d, act_q;

    always_comb begin
        act_d = 1'b1;
    end

    always_ff @(posedge tgt_clk or posedge clr) begin
        if (clr) act_q <= 1'b0;
        else     act_q <= act_d;
    end

    assign active = act_q;
endmodule

// File: rtl/dbg_cmd_unit.sv
module dbg_cmd_unit
    import dbg_cmd_pkg::*;
#(
    parameter int RST_CYCLES = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output logic       rsp_valid,
    output logic [7:0] rsp_byte,
    input  logic       tgt_clk,
    input  logic       tgt_rst_n,
    output logic       rst_req
);
    dec_regs_t        dec_d, dec_q;
    logic             timer_start;
    logic             in_data;
    logic             act_raw;
    logic             act_clr_async;
    logic [SYN_W-1:0] syn_in, syn_out;

    assign in_data = (dec_q.state == DEC_DATA);

    dbg_act_flag u_act (
        .tgt_clk (tgt_clk),
        .clr     (act_clr_async),
        .active  (act_raw)
    );

    assign act_clr_async = dec_q.act_clr | ~rst_n;

    always_comb begin
        syn_in          = '0;
        syn_in[SYN_CLK] = tgt_clk;
        syn_in[SYN_RST] = tgt_rst_n;
        syn_in[SYN_ACT] = act_raw;
    end

    dbg_sync2 #(.WIDTH(SYN_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (syn_in),
        .sync_out (syn_out)
    );

    dbg_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (timer_start),
        .rst_req (rst_req)
    );

    always_comb begin
        dec_d         = dec_q;
        dec_d.rsp_v   = 1'b0;
        dec_d.rsp_b   = '0;
        dec_d.act_clr = 1'b0;
        timer_start   = 1'b0;
        if (cmd_valid) begin
            if (in_data) begin
                dec_d.rsp_v = 1'b1;
                dec_d.rsp_b = cmd_byte;
                dec_d.state = DEC_OPCODE;
            end else begin
                case (cmd_byte)
                    OP_ECHO:     dec_d.state = DEC_DATA;
                    OP_RESET:    timer_start = 1'b1;
                    OP_SMP_CLK: begin
                        dec_d.rsp_v = 1'b1;
                        dec_d.rsp_b = {7'b0, syn_out[SYN_CLK]};
                    end
                    OP_SMP_RST: begin
                        dec_d.rsp_v = 1'b1;
                        dec_d.rsp_b = {7'b0, syn_out[SYN_RST]};
                    end
                    OP_ACT_CLR:  dec_d.act_clr = 1'b1;
                    OP_ACT_READ: begin
                        dec_d.rsp_v = 1'b1;
                        dec_d.rsp_b = {7'b0, syn_out[SYN_ACT]};
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign rsp_valid = dec_q.rsp_v;
    assign rsp_byte  = dec_q.rsp_b;
endmodule

// File: rtl/dbg_cmd_unit_chk.sv
module dbg_cmd_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       rsp_valid,
    input logic [7:0] rsp_byte,
    input logic       rst_req,
    input logic       in_data
);
    logic opc_ok;
    assign opc_ok = cmd_valid && !in_data;

    // R9
    rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid));

    // R1
    echo_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && in_data |=> rsp_valid && rsp_byte == $past(cmd_byte));

    // R4
    sample_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opc_ok && (cmd_byte == 8'h03 || cmd_byte == 8'h04 || cmd_byte == 8'h06)
        |=> rsp_valid && rsp_byte[7:1] == 7'b0);

    // R8
    undef_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opc_ok && (cmd_byte == 8'h00 || cmd_byte > 8'h06) |=> !rsp_valid);

    // R2
    reset_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(opc_ok && cmd_byte == 8'h02));

    // R3
    reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opc_ok && cmd_byte == 8'h02 |=> rst_req);
endmodule

bind dbg_cmd_unit dbg_cmd_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .rsp_valid (rsp_valid),
    .rsp_byte  (rsp_byte),
    .rst_req   (rst_req),
    .in_data   (in_data)
);

// File: tb/dbg_cmd_unit_test.sv
`timescale 1ns/1ps
module dbg_cmd_unit_test;
    localparam int RC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       rsp_valid;
    logic [7:0] rsp_byte;
    logic       tgt_clk = 1'b0;
    logic       tgt_rst_n = 1'b1;
    logic       rst_req;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_acc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbg_cmd_unit #(.RST_CYCLES(RC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .tgt_clk(tgt_clk),
        .tgt_rst_n(tgt_rst_n), .rst_req(rst_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one byte; check the response at the following negedge.
    task automatic send(input logic [7:0] b, input bit ev, input logic [7:0] eb, input string req);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        last_acc  = cyc;
        if (ev) chk(rsp_valid && rsp_byte == eb, req, {rsp_valid, rsp_byte}, {1'b1, eb});
        else    chk(!rsp_valid, req, {rsp_valid, rsp_byte}, 0);
    endtask

    task automatic echo(input logic [7:0] b, input string req);
        send(8'h01, 1'b0, 8'h00, req);
        send(b, 1'b1, b, req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count cycles rst_req is high after a reset command; optionally re-issue it.
    task automatic measure(input int retrig_at, output int n);
        bit again = 1'b0;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            if (!rst_req) break;
            n++;
            if (n == retrig_at && !again) begin
                cmd_valid = 1'b1; cmd_byte = 8'h02; again = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!rsp_valid && !rst_req, "R10", {rsp_valid, rst_req}, 0);
        rst_n = 1'b1;
        idle(2);
        chk(!rsp_valid && !rst_req, "R10", {rsp_valid, rst_req}, 0);
        send(8'h06, 1'b1, 8'h00, "R10");

        // R1: echo every byte value
        for (int v = 0; v < 256; v++) echo(8'(v), "R1");

        // R8: every undefined opcode is silent and harmless
        for (int v = 0; v < 256; v++) begin
            if (v >= 1 && v <= 6) continue;
            send(8'(v), 1'b0, 8'h00, "R8");
            chk(!rst_req, "R8", rst_req, 0);
        end
        echo(8'h5A, "R8");

        // R9: data after echo opcode is data, even if it matches an opcode
        for (int v = 1; v <= 6; v++) echo(8'(v), "R9");
        chk(!rst_req, "R9", rst_req, 0);
        send(8'h03, 1'b1, 8'h00, "R9");

        // R4 / R5: sample both levels of each input
        for (int lv = 0; lv < 2; lv++) begin
            tgt_clk = 1'(lv); tgt_rst_n = 1'(1 - lv);
            idle(3);
            send(8'h03, 1'b1, 8'(lv), "R4");
            send(8'h04, 1'b1, 8'(1 - lv), "R5");
        end
        tgt_clk = 1'b0; tgt_rst_n = 1'b1;
        idle(3);

        // R7 / R6: clear, stay clear, then set by a rising edge
        send(8'h05, 1'b0, 8'h00, "R7");
        idle(4);
        send(8'h06, 1'b1, 8'h00, "R7");
        #3 tgt_clk = 1'b1; #3 tgt_clk = 1'b0;
        idle(4);
        send(8'h06, 1'b1, 8'h01, "R6");
        send(8'h06, 1'b1, 8'h01, "R6");
        send(8'h05, 1'b0, 8'h00, "R7");
        idle(4);
        send(8'h06, 1'b1, 8'h00, "R7");

        // R2: plain pulse length
        send(8'h02, 1'b0, 8'h00, "R2");
        measure(0, n);
        chk(n == RC, "R2", n, RC);

        // R3: retrigger lengthens the pulse
        send(8'h02, 1'b0, 8'h00, "R3");
        measure(10, n);
        chk(n == RC + 10, "R3", n, RC + 10);

        // R11: answers during an active pulse; pulse end unchanged
        begin
            int a;
            send(8'h02, 1'b0, 8'h00, "R11");
            a = last_acc;
            echo(8'hA5, "R11");
            echo(8'h3C, "R11");
            send(8'h03, 1'b1, 8'h00, "R11");
            echo(8'h02, "R11");
            chk(rst_req, "R11", rst_req, 1);
            while (cyc < a + RC - 1) @(negedge clk);
            chk(rst_req, "R11", rst_req, 1);
            @(negedge clk);
            chk(!rst_req, "R11", rst_req, 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule